// File: doc/BRIEF.md
# Bit-Request Transmitter for a Wired Pulse Bus

This block sits in a slave device on a shared active-low line that a single master clocks. The master opens every frame with a long low period (the start block). It then sends a fixed number of bit slots, and each slot opens with a falling edge. A plain slot is a short low pulse. The master stretches the pulse to a long one when it sees that some slave has also pulled the line low early in the slot. This block lets the slave ask for a stretched pulse (a 1) in chosen slots.

The request for a slot is taken from a per-frame mask and placed in a hold register one slot ahead. The falling edge that opens the slot then fires the pull directly from flip-flops. The pull lasts a fixed fraction of the nominal slot time and ends well before the next slot starts. Later in the same slot the block samples the line. If the line is still low, the master has honoured the request, and the block records an acknowledge for that slot. When the frame ends, the block presents an acknowledge vector and an error flag for any requested slot that was not stretched. The block tracks the slot period from the spacing of successive falling edges, so slow drift in the master's timing does not disturb its start-block threshold or its sampling point.

Top module: `bsr_bit_requester`

## Requirements
- R1: When a frame is armed and the current slot is requested, `line_pull` rises exactly 2 clocks after the first rising clock edge that samples `line_in` low.
- R2: A pull lasts exactly REL = BIT_CYC*REL_PCT/100 clocks (20 with defaults) and is always released before the next slot's falling edge.
- R3: A low run on the line longer than SB_PCT percent (80) of the slot estimate, ended by a rising edge, starts a frame. The slot index returns to 0 and `tx_mask` is captured at that moment. Later changes to `tx_mask` have no effect until the next start block.
- R4: No pull is driven before the first start block after reset, nor in slots beyond the NBITS slots of a frame.
- R5: `ack_vec[i]` refers to frame slot i, with slot 0 being the first slot after the start block. It is 1 only if slot i was requested and the synchronised line is still low ACK_PCT percent (55) of the estimate after the slot's edge. With defaults the sample is taken of the line as seen 28 clocks after the slot's first low sample.
- R6: `frame_done` is a single-clock pulse, issued at the sample of slot NBITS-1. With default parameters it is high in the clock that follows the 30th rising edge after the slot's first low sample. `ack_vec` and `frame_err` update together with it.
- R7: `frame_err` is 1 after a frame only when some requested slot was not acknowledged.
- R8: The slot estimate `bit_est` resets to BIT_CYC. On each falling edge, an interval within plus or minus 25% of the estimate moves a four-times fixed-point estimate by (interval - estimate). Intervals outside that window leave it unchanged.
- R9: After reset, `line_pull`, `ack_vec`, `frame_done` and `frame_err` are 0 and `bit_est` equals BIT_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Raw level of the shared line, 1 = released |
| tx_mask | input | NBITS | Slots to request in the next frame, bit i = slot i |
| line_pull | output | 1 | 1 = drive the shared line low |
| ack_vec | output | NBITS | Slots acknowledged in the last completed frame |
| frame_done | output | 1 | One-clock pulse when a frame's results are updated |
| frame_err | output | 1 | A requested slot of the last frame was not stretched |
| bit_est | output | clog2(4*BIT_CYC+1) | Current slot-period estimate in clocks |

## Verification
The first low sample of `line_in` is the reference point for each slot. The pull is due 2 clocks later and must drop 20 clocks after it rises. The acknowledge sample reads the line as it was 28 clocks after the reference point, and `frame_done` follows 30 clocks after it with the defaults. The bench numbers its own clock edges and records the edge at which each slot's low level is first sampled. From that record it predicts the exact pull window and done cycle. It compares both against the outputs at every falling clock edge, away from the edge on which the design updates. The acknowledge vector, the error flag and the estimate change only at known points well inside a slot, so they are checked once per frame after the last slot has finished.

// File: rtl/bsr_pkg.sv
// Shared helpers for the bit-request transmitter.
// Assumes: percentages are whole numbers from 0 to 100.
package bsr_pkg;

    // Scale a cycle count by a percentage, rounding down.
    function automatic int unsigned pct_of(input int unsigned val, input int unsigned pct);
        return (val * pct) / 100;
    endfunction

endpackage

// File: rtl/bsr_line_sync.sv
// Brings the raw bus level into the clock domain and flags its edges.
// Assumes: the line idles high; reset loads the idle level so that no
// edge is reported while the flops leave reset.
module bsr_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall,
    output logic rise
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s = sync_q;
    assign fall   = prev_q & ~sync_q;
    assign rise   = ~prev_q & sync_q;

endmodule

// File: rtl/bsr_bit_timer.sv
// Time base for one slot: age since the last falling edge, start-block
// detection and a drift-tolerant slot-period estimate.
// Assumes: falling edges arrive as one-clock pulses from bsr_line_sync;
// the estimate carries two fractional bits.
module bsr_bit_timer #(
    parameter int BIT_CYC = 50,
    parameter int SB_PCT  = 80,
    parameter int ACK_PCT = 55,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_s,
    input  logic          fall,
    input  logic          rise,
    output logic [CW-1:0] age,
    output logic [CW-1:0] ack_pt,
    output logic          sb_seen,
    output logic [CW-1:0] est
);
    import bsr_pkg::*;

    localparam int EW = CW + 2;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] age_q;
    logic [CW-1:0] ivl_q;
    logic [CW-1:0] low_q;
    logic [EW-1:0] est_fx_q;
    logic          sb_q;
    logic [CW-1:0] quarter;
    logic [CW-1:0] win_lo;
    logic [CW:0]   win_hi;
    logic          in_win;
    logic [CW-1:0] sb_thr;

    assign est = est_fx_q[EW-1:2];

    // Acceptance window, start-block threshold and sample point from the estimate.
    always_comb begin
        quarter = est >> 2;
        win_lo  = est - quarter;
        win_hi  = {1'b0, est} + {1'b0, quarter};
        in_win  = (ivl_q >= win_lo) && ({1'b0, ivl_q} <= win_hi);
        sb_thr  = CW'(pct_of(32'(est), SB_PCT));
        ack_pt  = CW'(pct_of(32'(est), ACK_PCT));
    end

    // Age of the current slot, restarted by each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= CMAX;
        else if (fall)         age_q <= '0;
        else if (age_q != CMAX) age_q <= age_q + 1'b1;
    end

    // Interval between successive falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)             ivl_q <= CMAX;
        else if (fall)          ivl_q <= CW'(1);
        else if (ivl_q != CMAX) ivl_q <= ivl_q + 1'b1;
    end

    // Quarter-weight filter of accepted intervals in four-times fixed point.
    always_ff @(posedge clk) begin
        if (!rst_n)              est_fx_q <= EW'(BIT_CYC * 4);
        else if (fall && in_win) est_fx_q <= est_fx_q + EW'(ivl_q) - EW'(est);
    end

    // Length of the current low run.
    always_ff @(posedge clk) begin
        if (!rst_n)             low_q <= '0;
        else if (line_s)        low_q <= '0;
        else if (low_q != CMAX) low_q <= low_q + 1'b1;
    end

    // Start block: a long low run closed by a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= 1'b0;
        else        sb_q <= rise && (low_q > sb_thr);
    end

    assign age     = age_q;
    assign sb_seen = sb_q;

    // A start block is only reported on the clock after a rising edge.
    a_r3_sb_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sb_q |-> $past(rise));

endmodule

// File: rtl/bsr_req_seq.sv
// Slot sequencer: keeps the frame position, prefetches the next request
// into a hold register, fires the pull on the slot edge and collects the
// acknowledges.
// Assumes: age counts clocks since the slot's falling edge; REL_CYC is at
// least 1 and below the ack point.
module bsr_req_seq #(
    parameter int NBITS   = 8,
    parameter int REL_CYC = 20,
    parameter int CW      = 8,
    parameter int IW      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             line_s,
    input  logic             sb_seen,
    input  logic [CW-1:0]    age,
    input  logic [CW-1:0]    ack_pt,
    input  logic [NBITS-1:0] tx_mask,
    output logic             line_pull,
    output logic [NBITS-1:0] ack_vec,
    output logic             frame_done,
    output logic             frame_err
);

    localparam logic [IW-1:0] LAST = IW'(NBITS - 1);
    localparam logic [IW-1:0] DONE = IW'(NBITS);

    logic [NBITS-1:0] mask_q;
    logic [NBITS-1:0] acc_q;
    logic [NBITS-1:0] ack_q;
    logic [IW-1:0]    idx_q;
    logic [IW-1:0]    cur_idx_q;
    logic             hold_q;
    logic             pull_q;
    logic             cur_req_q;
    logic             in_bit_q;
    logic             done_q;
    logic             err_q;
    logic             armed;
    logic             nxt_bit;
    logic             ack_hit;
    logic [NBITS-1:0] acc_nxt;

    assign armed = idx_q < DONE;

    // Request bit for the slot after the current one.
    always_comb begin
        nxt_bit = 1'b0;
        for (int i = 0; i < NBITS - 1; i++) begin
            if (idx_q == IW'(i)) nxt_bit = mask_q[i + 1];
        end
    end

    // Sample point reached; fold this slot's result into the frame vector.
    always_comb begin
        ack_hit = in_bit_q && (age == ack_pt);
        acc_nxt = acc_q;
        if (cur_req_q && !line_s) acc_nxt = acc_q | (NBITS'(1) << cur_idx_q);
    end

    // Frame position and one-ahead request prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= DONE;
            mask_q    <= '0;
            hold_q    <= 1'b0;
            cur_idx_q <= '0;
            cur_req_q <= 1'b0;
        end else if (sb_seen) begin
            idx_q  <= '0;
            mask_q <= tx_mask;
            hold_q <= tx_mask[0];
        end else if (fall && armed) begin
            idx_q     <= idx_q + 1'b1;
            hold_q    <= nxt_bit;
            cur_idx_q <= idx_q;
            cur_req_q <= hold_q;
        end
    end

    // Pull driver: launched by the slot edge, released after REL_CYC clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pull_q <= 1'b0;
        else if (fall)                                pull_q <= armed & hold_q;
        else if (pull_q && age == CW'(REL_CYC - 1))   pull_q <= 1'b0;
    end

    // Acknowledge collection and end-of-frame results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_bit_q <= 1'b0;
            acc_q    <= '0;
            ack_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sb_seen) begin
                in_bit_q <= 1'b0;
                acc_q    <= '0;
            end else if (fall && armed) begin
                in_bit_q <= 1'b1;
            end else if (ack_hit) begin
                in_bit_q <= 1'b0;
                acc_q    <= acc_nxt;
                if (cur_idx_q == LAST) begin
                    ack_q  <= acc_nxt;
                    err_q  <= |(mask_q & ~acc_nxt);
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign line_pull  = pull_q;
    assign ack_vec    = ack_q;
    assign frame_done = done_q;
    assign frame_err  = err_q;

    // R1: an armed, requested slot edge drives the line on the next clock.
    a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && armed && hold_q) |=> pull_q);
    // R2: the pull never outlives its window within the slot.
    a_r2_pull_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pull_q |-> (age < CW'(REL_CYC)));
    // R4: once the frame is used up, the line stays released.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == DONE && !pull_q) |=> !pull_q);
    // R3: a start block restarts the frame bookkeeping.
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sb_seen |=> (idx_q == '0 && acc_q == '0 && !in_bit_q));
    // R6: the done pulse is one clock wide.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/bsr_bit_requester.sv
// Top of the slave bit-request transmitter: synchroniser, slot time base
// and slot sequencer.
// Assumes: line_in is the raw, asynchronous bus level including this
// block's own pull; line_pull drives an open-drain output outside.
module bsr_bit_requester #(
    parameter int BIT_CYC = 50,
    parameter int NBITS   = 8,
    parameter int REL_PCT = 40,
    parameter int ACK_PCT = 55,
    parameter int SB_PCT  = 80,
    localparam int CW     = $clog2(BIT_CYC * 4 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic [NBITS-1:0] tx_mask,
    output logic             line_pull,
    output logic [NBITS-1:0] ack_vec,
    output logic             frame_done,
    output logic             frame_err,
    output logic [CW-1:0]    bit_est
);
    import bsr_pkg::*;

    localparam int REL_CYC = int'(pct_of(BIT_CYC, REL_PCT));
    localparam int IW      = $clog2(NBITS + 1);

    logic          line_s;
    logic          fall;
    logic          rise;
    logic [CW-1:0] age;
    logic [CW-1:0] ack_pt;
    logic          sb_seen;

    bsr_line_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .line_s  (line_s),
        .fall    (fall),
        .rise    (rise)
    );

    bsr_bit_timer #(
        .BIT_CYC (BIT_CYC),
        .SB_PCT  (SB_PCT),
        .ACK_PCT (ACK_PCT),
        .CW      (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .fall    (fall),
        .rise    (rise),
        .age     (age),
        .ack_pt  (ack_pt),
        .sb_seen (sb_seen),
        .est     (bit_est)
    );

    bsr_req_seq #(
        .NBITS   (NBITS),
        .REL_CYC (REL_CYC),
        .CW      (CW),
        .IW      (IW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .line_s     (line_s),
        .sb_seen    (sb_seen),
        .age        (age),
        .ack_pt     (ack_pt),
        .tx_mask    (tx_mask),
        .line_pull  (line_pull),
        .ack_vec    (ack_vec),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

endmodule

// File: tb/bsr_bit_requester_test.sv
// Bench: a behavioural master and a per-clock reference of the pull window.
module bsr_bit_requester_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8;
    localparam int NOM        = 50;
    localparam int REL        = NOM * 40 / 100;   // 20 clocks of pull
    localparam int DONE_OFS   = NOM * 55 / 100 + 3; // 30 clocks to done
    localparam int EW_OUT     = $clog2(NOM * 4 + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              m_low = 1'b0;
    logic [NB-1:0]     tx_mask = '0;
    logic              line_in;
    logic              line_pull;
    logic [NB-1:0]     ack_vec;
    logic              frame_done;
    logic              frame_err;
    logic [EW_OUT-1:0] bit_est;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_p0 = -1000;
    int exp_done_cyc = -1000;
    bit exp_req = 1'b0;
    bit done_chk = 1'b1;
    bit running = 1'b0;
    bit synced = 1'b0;
    int k = NB;
    logic [NB-1:0] lat = '0;

    assign line_in = !(m_low || line_pull);

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsr_bit_requester #(.BIT_CYC(NOM), .NBITS(NB)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .tx_mask    (tx_mask),
        .line_pull  (line_pull),
        .ack_vec    (ack_vec),
        .frame_done (frame_done),
        .frame_err  (frame_err),
        .bit_est    (bit_est)
    );

    // Number of rising clock edges since time zero.
    always @(posedge clk) cyc <= cyc + 1;

    // Per-clock reference: pull window (R1 R2 R4) and done cycle (R6).
    always @(negedge clk) begin
        if (running) begin
            bit exp_pull;
            exp_pull = exp_req && (cyc >= exp_p0 + 2) && (cyc <= exp_p0 + REL + 1);
            tests++;
            if (line_pull !== exp_pull) begin
                fails++;
                $display("FAIL R1 R2 R4 line_pull at cycle %0d: act=%0b exp=%0b", cyc, line_pull, exp_pull);
            end
            if (done_chk) begin
                bit exp_d;
                exp_d = (cyc == exp_done_cyc);
                tests++;
                if (frame_done !== exp_d) begin
                    fails++;
                    $display("FAIL R6 frame_done at cycle %0d: act=%0b exp=%0b", cyc, frame_done, exp_d);
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One master slot; entered and left on a falling clock edge.
    task automatic slot(input int period, input bit stretch_ok);
        int low_len;
        bit seen;
        exp_req = synced && (k < NB) && lat[k];
        exp_p0  = cyc + 1;
        if (synced && k == NB - 1) exp_done_cyc = cyc + 1 + DONE_OFS;
        if (synced && k < NB) k++;
        m_low = 1'b1;
        repeat (10) @(negedge clk);
        seen = line_pull;
        low_len = (seen && stretch_ok) ? period * 70 / 100 : period / 4;
        repeat (low_len - 10) @(negedge clk);
        m_low = 1'b0;
        repeat (period - low_len) @(negedge clk);
    endtask

    // Start block: long low then a high gap.
    task automatic start_block();
        exp_req = 1'b0;
        m_low = 1'b1;
        repeat (70) @(negedge clk);
        m_low = 1'b0;
        lat = tx_mask;
        synced = 1'b1;
        k = 0;
        repeat (30) @(negedge clk);
    endtask

    task automatic frame(input logic [NB-1:0] mask, input logic [NB-1:0] stretch,
                         input logic [NB-1:0] mask_after, input int period, input string tag);
        tx_mask = mask;
        start_block();
        tx_mask = mask_after; // R3: must not affect this frame
        for (int i = 0; i < NB; i++) slot(period, stretch[i]);
        check({"R5 ack_vec ", tag}, int'(ack_vec), int'(mask & stretch));
        check({"R7 frame_err ", tag}, int'(frame_err), int'(|(mask & ~stretch)));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        check("R9 line_pull", int'(line_pull), 0);
        check("R9 ack_vec", int'(ack_vec), 0);
        check("R9 frame_done", int'(frame_done), 0);
        check("R9 frame_err", int'(frame_err), 0);
        check("R9 bit_est", int'(bit_est), NOM);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;

        // R4: slots before any start block draw no pull.
        tx_mask = '1;
        for (int i = 0; i < 3; i++) slot(NOM, 1'b1);

        frame(8'hA5, 8'hFF, 8'hA5, NOM, "A");
        check("R8 bit_est steady", int'(bit_est), NOM);
        frame(8'h3C, 8'hFF, 8'hFF, NOM, "B"); // R3 mask captured at start block
        // R4: slots past the end of a frame draw no pull.
        for (int i = 0; i < 2; i++) slot(NOM, 1'b1);
        frame(8'h81, 8'h7F, 8'h81, NOM, "C");
        frame(8'h00, 8'hFF, 8'h00, NOM, "D");
        // R8: an outlier interval must be ignored.
        slot(70, 1'b1);
        slot(NOM, 1'b1);
        check("R8 bit_est outlier ignored", int'(bit_est), NOM);

        // R8: slow drift to a 54-clock slot.
        done_chk = 1'b0;
        for (int f = 0; f < 3; f++) frame(8'hFF, 8'hFF, 8'hFF, 54, "drift");
        check("R8 bit_est tracked", int'(bit_est), 54);

        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

endmodule